// File: doc/BRIEF.md
# Two-Step Column Time Counter with Quarter-Period Interpolation

This block turns the delay between a conversion start and the comparator's rising edge into a 12-bit code for one column of a single-slope converter. A coarse counter counts whole counter-clock periods. Its two low bits step in Gray order, and the top bit of that pair clocks an eight-bit chain of toggle stages that ripple from one to the next. A fine stage resolves which quarter of the period the comparator edge fell in. It does this by sampling four copies of the counter clock that are each a quarter period apart. Because coarse and fine run at the same time, a full-resolution conversion needs only a quarter of the clock periods that a plain counter would need.

The fine stage is armed only by the first comparator rise of a conversion. The coarse count stops at the next counter-clock edge of either polarity, so the span from the event to the freeze is at most half a period. An edge in the second half of a period lets one extra coarse increment through, and the result logic subtracts it. The result is registered one full period after the freeze, when the ripple chain has settled. Running out of range without a comparator edge gives an all-ones code.

Top module: `tq_two_step_counter`

## Requirements
- R1: While the asynchronous active-low reset is applied, and after it is released, the result reads 0 and the done flag is low.
- R2: Let time zero be the first counter-clock rising edge after the edge on which start was sampled high. For a comparator rise at any time t before 4096 quarter periods, the result equals floor(t / (period/4)).
- R3: Phase input k is the counter clock delayed by k quarter periods, and bit 0 is in phase with the counter clock. The two low result bits are the quarter index decoded from the phases sampled at the comparator rise: (phase0, phase1) = (1,0) gives 0, (1,1) gives 1, (0,1) gives 2 and (0,0) gives 3.
- R4: The two low coarse bits count in the Gray order 00, 01, 11, 10. The upper eight bits advance when the Gray section wraps. The result stays correct across every carry into the upper section, including from 1023 periods down to the last quarter.
- R5: For a rise in the second half of a period (quarter 2 or 3), the coarse count freezes one rising edge later than for a rise in the first half, and the result removes the extra count.
- R6: Done rises on rising edge number j+2 after time zero, or j+3 when the quarter index is 2 or 3, where j is the period holding the rise. It never rises later than edge 1026.
- R7: With no comparator rise, the coarse count holds at full scale. Done rises on rising edge 1026 with the result at 4095.
- R8: A comparator rise at or beyond 4096 quarter periods gives 4095.
- R9: Only the first comparator rise of a conversion counts. A later rise, before or after done, changes neither the result nor the done timing.
- R10: Start clears done and the result on the edge where it is sampled, and it re-arms a new conversion even mid-count. A comparator rise before any start after reset changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_cnt_i | input | 1 | Counter clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Synchronous start pulse, one counter-clock cycle |
| cmp_i | input | 1 | Comparator output, event on its rising edge |
| phase_i | input | 4 | Counter clock copies delayed by 0..3 quarter periods |
| result_o | output | 12 | Converted time code |
| done_o | output | 1 | Result valid, held until the next start |

## Verification
The bench places comparator edges in the middle of each quarter. It sweeps every code up to 79, all four quarters around each carry into the upper section, and a coarse stride across the full range. A missing second-half correction shows up as results one period too high on quarters 2 and 3. A wrong Gray order or ripple tap shows up as jumps at multiples of 16, 256 or 1024. Full-scale runs, both without an edge and with edges just past full scale, catch a counter that wraps instead of saturating. A doubled comparator pulse and a restart mid-count catch a fine stage that re-arms or a start that leaves old state behind.

// File: rtl/tq_pkg.sv
`timescale 1ns/1ps
package tq_pkg;

    localparam int GRAY_W  = 2;
    localparam int FINE_W  = 2;
    localparam int PHASE_N = 4;

    function automatic logic [GRAY_W-1:0] gray_to_bin(input logic [GRAY_W-1:0] g);
        return {g[1], g[1] ^ g[0]};
    endfunction

    function automatic logic [GRAY_W-1:0] bin_to_gray(input logic [GRAY_W-1:0] b);
        return {b[1], b[1] ^ b[0]};
    endfunction

    // Sampled phases, bit k = clock delayed by k quarters.
    function automatic logic [FINE_W-1:0] quarter_code(input logic [PHASE_N-1:0] p);
        logic [FINE_W-1:0] c;
        case (p)
            4'b1001: c = 2'd0;
            4'b0011: c = 2'd1;
            4'b0110: c = 2'd2;
            4'b1100: c = 2'd3;
            default: c = {~p[0], ~(p[0] ^ p[1])};
        endcase
        return c;
    endfunction

endpackage

// File: rtl/tq_gray_lo.sv
`timescale 1ns/1ps
module tq_gray_lo
    import tq_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              clr_i,
    input  logic              en_i,
    output logic [GRAY_W-1:0] gray_o
);

    logic [GRAY_W-1:0] gray_d, gray_q;

    always_comb begin
        gray_d = gray_q;
        if (clr_i) begin
            gray_d = '0;
        end else if (en_i) begin
            gray_d = bin_to_gray(gray_to_bin(gray_q) + 2'd1);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            gray_q <= '0;
        end else begin
            gray_q <= gray_d;
        end
    end

    assign gray_o = gray_q;

    // R4: every counted step flips exactly one bit
    a_r4_gray_single_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(en_i) && !$past(clr_i)) |-> ($countones(gray_q ^ $past(gray_q)) == 1));

endmodule

// File: rtl/tq_ripple_hi.sv
`timescale 1ns/1ps
module tq_ripple_hi #(
    parameter int W = 8
) (
    input  logic         src_i,
    input  logic         clr_i,
    output logic [W-1:0] cnt_o,
    output logic         ovf_o
);

    logic ovf_q;

    for (genvar k = 0; k < W; k++) begin : g_stage
        logic tick;
        logic bit_q;
        if (k == 0) begin : g_first
            assign tick = src_i;
        end else begin : g_next
            assign tick = cnt_o[k-1];
        end
        always_ff @(negedge tick or posedge clr_i) begin
            if (clr_i) begin
                bit_q <= 1'b0;
            end else begin
                bit_q <= ~bit_q;
            end
        end
        assign cnt_o[k] = bit_q;
    end

    always_ff @(negedge cnt_o[W-1] or posedge clr_i) begin
        if (clr_i) begin
            ovf_q <= 1'b0;
        end else begin
            ovf_q <= 1'b1;
        end
    end

    assign ovf_o = ovf_q;

endmodule

// File: rtl/tq_fine_edge.sv
`timescale 1ns/1ps
module tq_fine_edge
    import tq_pkg::*;
(
    input  logic               clk_i,
    input  logic               clr_i,
    input  logic               arm_i,
    input  logic               cmp_i,
    input  logic [PHASE_N-1:0] phase_i,
    output logic               hit_o,
    output logic               stop_n_o,
    output logic [PHASE_N-1:0] thermo_o
);

    logic               hit_q;
    logic               stop_n_q;
    logic [PHASE_N-1:0] thermo_q;

    // Event capture: first armed comparator rise only.
    always_ff @(posedge cmp_i or posedge clr_i) begin
        if (clr_i) begin
            hit_q    <= 1'b0;
            thermo_q <= '0;
        end else if (arm_i && !hit_q) begin
            hit_q    <= 1'b1;
            thermo_q <= phase_i;
        end
    end

    // Falling-edge half of the dual-edge stop detector.
    always_ff @(negedge clk_i or posedge clr_i) begin
        if (clr_i) begin
            stop_n_q <= 1'b0;
        end else begin
            stop_n_q <= hit_q;
        end
    end

    assign hit_o    = hit_q;
    assign stop_n_o = stop_n_q;
    assign thermo_o = thermo_q;

endmodule

// File: rtl/tq_two_step_counter.sv
`timescale 1ns/1ps
module tq_two_step_counter
    import tq_pkg::*;
#(
    parameter int RIPPLE_W = 8
) (
    input  logic                                clk_cnt_i,
    input  logic                                rst_ni,
    input  logic                                start_i,
    input  logic                                cmp_i,
    input  logic [3:0]                          phase_i,
    output logic [RIPPLE_W+GRAY_W+FINE_W-1:0]   result_o,
    output logic                                done_o
);

    localparam int RES_W = RIPPLE_W + GRAY_W + FINE_W;
    localparam int EXT_W = RIPPLE_W + GRAY_W + 1;

    typedef struct packed {
        logic             clr;
        logic             run;
        logic             stop_p;
        logic             pend;
        logic             sat;
        logic             done;
        logic [RES_W-1:0] result;
    } ctrl_t;

    ctrl_t ctrl_d, ctrl_q;

    logic                clr_async;
    logic                hit;
    logic                stop_n;
    logic [PHASE_N-1:0]  thermo;
    logic                stopped;
    logic [GRAY_W-1:0]   gray;
    logic [RIPPLE_W-1:0] upper;
    logic                ovf;
    logic                gray_en;
    logic [FINE_W-1:0]   fine_code;
    logic [EXT_W-1:0]    ext;
    logic [EXT_W-1:0]    corr;
    logic [RES_W-1:0]    res_calc;

    assign clr_async = ctrl_q.clr | ~rst_ni;
    assign stopped   = stop_n | ctrl_q.stop_p;
    assign gray_en   = ctrl_q.run & ~stopped & ~ovf & ~ctrl_q.pend;

    tq_fine_edge u_fine (
        .clk_i    (clk_cnt_i),
        .clr_i    (clr_async),
        .arm_i    (ctrl_q.run),
        .cmp_i    (cmp_i),
        .phase_i  (phase_i),
        .hit_o    (hit),
        .stop_n_o (stop_n),
        .thermo_o (thermo)
    );

    tq_gray_lo u_gray (
        .clk_i  (clk_cnt_i),
        .rst_ni (rst_ni),
        .clr_i  (start_i),
        .en_i   (gray_en),
        .gray_o (gray)
    );

    tq_ripple_hi #(.W(RIPPLE_W)) u_upper (
        .src_i (gray[GRAY_W-1]),
        .clr_i (clr_async),
        .cnt_o (upper),
        .ovf_o (ovf)
    );

    always_comb begin
        fine_code = quarter_code(thermo);
        ext       = {ovf, upper, gray_to_bin(gray)};
        corr      = ext - EXT_W'(fine_code[FINE_W-1]);
        if (ctrl_q.sat || corr[EXT_W-1]) begin
            res_calc = '1;
        end else begin
            res_calc = {corr[EXT_W-2:0], fine_code};
        end
    end

    always_comb begin
        ctrl_d     = ctrl_q;
        ctrl_d.clr = start_i;
        if (start_i) begin
            ctrl_d.run    = 1'b0;
            ctrl_d.stop_p = 1'b0;
            ctrl_d.pend   = 1'b0;
            ctrl_d.sat    = 1'b0;
            ctrl_d.done   = 1'b0;
            ctrl_d.result = '0;
        end else begin
            if (ctrl_q.clr) begin
                ctrl_d.run = 1'b1;
            end
            ctrl_d.stop_p = hit;
            if (ctrl_q.run && !ctrl_q.pend && (stopped || ovf)) begin
                ctrl_d.pend = 1'b1;
                ctrl_d.sat  = ~stopped;
            end
            if (ctrl_q.pend) begin
                ctrl_d.pend   = 1'b0;
                ctrl_d.run    = 1'b0;
                ctrl_d.done   = 1'b1;
                ctrl_d.result = res_calc;
            end
        end
    end

    always_ff @(posedge clk_cnt_i or negedge rst_ni) begin
        if (!rst_ni) begin
            ctrl_q <= '0;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    assign result_o = ctrl_q.result;
    assign done_o   = ctrl_q.done;

    // R5: once the stop is seen, the coarse count no longer moves
    a_r5_coarse_frozen: assert property (@(posedge clk_cnt_i) disable iff (!rst_ni)
        (stopped && $past(stopped) && !$past(start_i)) |-> ($stable(gray) && $stable(upper)));

    // R9: the sampled phases stay put after the first event
    a_r9_fine_locked: assert property (@(posedge clk_cnt_i) disable iff (!rst_ni)
        (stopped && $past(stopped)) |-> $stable(thermo));

    // R6: done only follows a settle cycle
    a_r6_done_after_settle: assert property (@(posedge clk_cnt_i) disable iff (!rst_ni)
        $rose(ctrl_q.done) |-> $past(ctrl_q.pend));

    // R7: at full scale the coarse count holds
    a_r7_hold_full: assert property (@(posedge clk_cnt_i) disable iff (!rst_ni)
        (ovf && $past(ovf)) |-> $stable(gray));

    // R10: start clears the outputs
    a_r10_start_clears: assert property (@(posedge clk_cnt_i) disable iff (!rst_ni)
        start_i |=> (!done_o && (result_o == '0)));

endmodule

// File: tb/tb_tq_two_step_counter.sv
`timescale 1ns/1ps
module tb_tq_two_step_counter;

    localparam real TP = 20.0;
    localparam real TQ = 5.0;

    logic        clk;
    logic        rst_n;
    logic        start;
    logic        cmp;
    logic [3:0]  ph;
    logic [11:0] result;
    logic        done;

    int checks = 0;
    int errors = 0;
    int qi;

    tq_two_step_counter dut (
        .clk_cnt_i (clk),
        .rst_ni    (rst_n),
        .start_i   (start),
        .cmp_i     (cmp),
        .phase_i   (ph),
        .result_o  (result),
        .done_o    (done)
    );

    initial begin
        qi = 0;
        forever begin
            for (int k = 0; k < 4; k++) ph[k] = (((qi - k + 4) % 4) < 2);
            clk = ph[0];
            #(TQ);
            qi = (qi + 1) % 4;
        end
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $realtime);
        end
    endtask

    task automatic do_start(output realtime s1);
        realtime s0;
        @(negedge clk);
        start = 1'b1;
        @(posedge clk);
        s0 = $realtime;
        @(negedge clk);
        start = 1'b0;
        s1 = s0 + TP;
        chk(done == 1'b0, "R10", done, 0);
        chk(result == 12'd0, "R10", result, 0);
    endtask

    // n1 < 0: no comparator edge; n2 >= 0: a second rise later on
    task automatic conv(input int n1, input int n2, input string req);
        realtime s1, td, te;
        int exp, j, h, lat, k;
        do_start(s1);
        if (n1 >= 0) begin
            #(s1 + n1 * TQ + 2.5 - $realtime);
            cmp = 1'b1;
            #2;
            cmp = 1'b0;
        end
        if (n2 >= 0) begin
            #(s1 + n2 * TQ + 2.5 - $realtime);
            cmp = 1'b1;
            #2;
            cmp = 1'b0;
        end
        k = 0;
        while (!done && k < 1500) begin
            @(negedge clk);
            k++;
        end
        td  = $realtime;
        exp = (n1 < 0 || n1 > 4095) ? 4095 : n1;
        j   = (n1 < 0) ? 1024 : n1 / 4;
        h   = (n1 >= 0 && (n1 % 4) >= 2) ? 1 : 0;
        lat = j + 2 + h;
        if (lat > 1026) lat = 1026;
        te  = s1 + lat * TP + TP / 2;
        chk(done == 1'b1, "R6", done, 1);
        chk(result == 12'(exp), req, result, exp);
        chk((td - te) < 0.5 && (te - td) < 0.5, "R6", longint'(td), longint'(te));
    endtask

    initial begin
        #(200000 * TP);
        errors++;
        $display("FAIL R6 watchdog actual=timeout expected=completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int mlist[8];
        realtime dummy;
        rst_n = 1'b0;
        start = 1'b0;
        cmp   = 1'b0;
        repeat (3) @(negedge clk);
        chk(result == 12'd0, "R1", result, 0);
        chk(done == 1'b0, "R1", done, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(result == 12'd0, "R1", result, 0);
        chk(done == 1'b0, "R1", done, 0);

        // R10: a comparator rise before any start is ignored
        #3 cmp = 1'b1;
        #2 cmp = 1'b0;
        repeat (4) @(negedge clk);
        chk(done == 1'b0, "R10", done, 0);
        chk(result == 12'd0, "R10", result, 0);

        // R2 / R3: every code of the first twenty periods
        for (int n = 0; n < 80; n++) conv(n, -1, "R3");

        // R4 / R5: all quarters around each carry into the upper section
        mlist = '{3, 4, 15, 16, 63, 64, 255, 256};
        for (int i = 0; i < 8; i++)
            for (int q = 0; q < 4; q++)
                conv(4 * mlist[i] + q, -1, (q >= 2) ? "R5" : "R4");
        mlist = '{511, 512, 767, 768, 1000, 1021, 1022, 1023};
        for (int i = 0; i < 8; i++)
            for (int q = 0; q < 4; q++)
                conv(4 * mlist[i] + q, -1, (q >= 2) ? "R5" : "R4");

        // R2: stride across the range
        for (int n = 81; n < 4096; n += 53) conv(n, -1, "R2");

        // R7: no comparator edge at all
        conv(-1, -1, "R7");
        // R8: edges at and past full scale
        conv(4096, -1, "R8");
        conv(4097, -1, "R8");
        conv(4100, -1, "R8");
        conv(4102, -1, "R8");

        // R9: second rise inside the same conversion
        conv(40, 44, "R9");
        conv(6, 7, "R9");
        conv(123, 127, "R9");
        // R9: rise after done leaves the result alone
        #3 cmp = 1'b1;
        #2 cmp = 1'b0;
        repeat (3) @(negedge clk);
        chk(result == 12'd123, "R9", result, 123);
        chk(done == 1'b1, "R9", done, 1);

        // R10: restart in the middle of a count
        do_start(dummy);
        repeat (30) @(negedge clk);
        chk(done == 1'b0, "R10", done, 0);
        conv(17, -1, "R10");
        conv(2, -1, "R10");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule